// File: doc/BRIEF.md
# Buffered Interval Timer

This block is an up-counting interval timer with two compare channels. Software programs each channel through a compare register. The comparators never look at those registers. They look at a buffer register behind each one. Compare channel 0 sets the period: when the counter reaches buffer 0, it returns to zero and the period starts again. Compare channel 1 marks a point inside the period and leaves the counter alone. A third event reports that the counter wrapped from all ones to zero.

The buffers are filled in one of two ways, chosen by a control bit:

- **Immediate:** every compare write goes straight into its buffer, even while the timer runs.
- **Batch:** writes wait in the compare registers. Both buffers are then loaded together at the next compare-0 match, but only if compare register 1 was written since the last load. Software therefore writes channel 1 last, which commits a coherent pair of values.

Top module: `itmr_top`

## Requirements
- R1: After reset the count output is 0, all three interrupt outputs are low and the timer is disabled.
- R2: Writes use `wr_addr` 0 for control (bit 0 enables the timer; bit 1 selects batch mode when 1 and immediate mode when 0), `wr_addr` 1 for compare register 0 and `wr_addr` 2 for compare register 1. While enabled, the count rises by one every clock unless it is being cleared by a compare-0 match.
- R3: The write that sets the enable bit while the timer is disabled loads both buffers from the compare registers. The count reads 0 in the following cycle.
- R4: `irq_cmp0` is high in every enabled cycle in which the count equals buffer 0. The count is 0 in the next cycle, so the period is buffer 0 plus one clocks.
- R5: `irq_cmp1` is high in every enabled cycle in which the count equals buffer 1. The count keeps advancing after that cycle.
- R6: `irq_ovf` is high in every enabled cycle in which the count is all ones. The count is 0 in the next cycle.
- R7: In immediate mode, a compare write updates its buffer at the same clock edge, so the comparison uses the new value from the next cycle on, while running or not.
- R8: In batch mode, compare writes leave the buffers unchanged until a compare-0 match that follows a write to compare register 1. At that match both buffers are loaded together.
- R9: In batch mode, a write to compare register 0 alone never changes either buffer.
- R10: The write that clears the enable bit makes the count read 0 from the next cycle. No interrupt output is high while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare 0, 2 compare 1 |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| irq_cmp0 | output | 1 | Compare-0 match pulse |
| irq_cmp1 | output | 1 | Compare-1 match pulse |
| irq_ovf | output | 1 | Counter wrap pulse |

## Verification
The bench builds the timer with `CNT_W` set to 8 instead of the default 16. With that width the counter can wrap through all ones within a few hundred cycles, so the overflow pulse, a maximum period and a compare-1 value beyond the period are all exercised in a short run. Every other behaviour is width-independent and is checked the same way: period length, mid-period events, and the immediate and batch transfer paths.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   localparam int NCH = 2;
   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_BATCH_BIT = 1;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CMP0 = 2'd1,
      SEL_CMP1 = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
   import itmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_addr,
   input  logic [CNT_W-1:0]            wr_data,
   input  logic                        match0,
   output logic                        en_q,
   output logic                        en_d,
   output logic                        batch_q,
   output logic                        start,
   output logic                        xfer,
   output logic [NCH-1:0]              imm_ld,
   output logic [NCH-1:0][CNT_W-1:0]   cmp_q
);
   logic             wr_ctrl;
   logic [NCH-1:0]   wr_cmp;
   logic             pend_q;

   assign wr_ctrl = wr_en && (wr_addr == SEL_CTRL);
   assign en_d    = wr_ctrl ? wr_data[CTRL_EN_BIT] : en_q;
   assign start   = en_d && !en_q;
   assign xfer    = match0 && pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         batch_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q    <= wr_data[CTRL_EN_BIT];
         batch_q <= wr_data[CTRL_BATCH_BIT];
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_cmp
      assign wr_cmp[i] = wr_en && (wr_addr == 2'(int'(SEL_CMP0) + i));
      assign imm_ld[i] = wr_cmp[i] && !batch_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         cmp_q[i] <= '0;
         else if (wr_cmp[i]) cmp_q[i] <= wr_data;
      end
   end

   // Batch commit is armed only by a write to the last channel.
   always_ff @(posedge clk) begin
      if (!rst_n)                           pend_q <= 1'b0;
      else if (wr_cmp[NCH-1] && batch_q)    pend_q <= 1'b1;
      else if (xfer || start)               pend_q <= 1'b0;
   end

   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !wr_cmp[NCH-1]) |=> !pend_q);   // R8
   AST_CMP0_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && batch_q && wr_cmp[0] && !wr_cmp[NCH-1]) |=> !pend_q);   // R9
endmodule

// File: rtl/itmr_buf.sv
module itmr_buf #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_all,
   input  logic             imm_ld,
   input  logic [CNT_W-1:0] imm_data,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] buf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)        buf_q <= '0;
      else if (load_all) buf_q <= cmp_val;
      else if (imm_ld)   buf_q <= imm_data;
   end
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_q,
   input  logic             en_d,
   input  logic [CNT_W-1:0] buf0,
   input  logic [CNT_W-1:0] buf1,
   output logic [CNT_W-1:0] cnt_q,
   output logic             match0,
   output logic             match1,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic hit0;

   assign hit0   = (cnt_q == buf0);
   assign match0 = en_q && hit0;
   assign match1 = en_q && (cnt_q == buf1);
   assign ovf    = en_q && (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en_d || !en_q) cnt_q <= '0;
      else if (hit0)           cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && en_d && !hit0) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));   // R2
   AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (match0 && en_d) |=> (cnt_q == '0));   // R4
   AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && en_d) |=> (cnt_q == '0));   // R6
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (cnt_q == '0));   // R10
   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_d && !en_q) |=> (cnt_q == '0));   // R3
endmodule

// File: rtl/itmr_top.sv
module itmr_top
   import itmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             irq_cmp0,
   output logic             irq_cmp1,
   output logic             irq_ovf
);
   if (CNT_W < 2) begin : g_chk_min
      $error("itmr_top: CNT_W must be at least 2 to hold the control bits");
   end
   if (CNT_W > 32) begin : g_chk_max
      $error("itmr_top: CNT_W above 32 is not supported");
   end

   logic                       en_q, en_d, batch_q, start, xfer, match0;
   logic [NCH-1:0]             imm_ld;
   logic [NCH-1:0][CNT_W-1:0]  cmp_q;
   logic [NCH-1:0][CNT_W-1:0]  buf_q;

   itmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .match0(match0), .en_q(en_q), .en_d(en_d),
      .batch_q(batch_q), .start(start), .xfer(xfer), .imm_ld(imm_ld),
      .cmp_q(cmp_q)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_buf
      itmr_buf #(.CNT_W(CNT_W)) u_buf (
         .clk(clk), .rst_n(rst_n), .load_all(start || xfer),
         .imm_ld(imm_ld[i]), .imm_data(wr_data), .cmp_val(cmp_q[i]),
         .buf_q(buf_q[i])
      );
   end

   itmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_d(en_d),
      .buf0(buf_q[0]), .buf1(buf_q[1]), .cnt_q(count),
      .match0(match0), .match1(irq_cmp1), .ovf(irq_ovf)
   );

   assign irq_cmp0 = match0;

   AST_BATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (batch_q && !xfer && !start) |=> $stable(buf_q));   // R8
   AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_ld[1] && !start) |=> (buf_q[1] == $past(wr_data)));   // R7
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !(irq_cmp0 || irq_cmp1 || irq_ovf));   // R10
endmodule

// File: tb/itmr_top_bench.sv
module itmr_top_bench;
   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;
   localparam int NVEC = 6;
   // {compare 0, compare 1, cycles to run}
   localparam int VEC [NVEC][3] = '{
      '{5, 2, 20}, '{0, 0, 6}, '{1, 1, 9}, '{7, 9, 30},
      '{3, 3, 14}, '{255, 100, 560}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count;
   logic         irq_cmp0, irq_cmp1, irq_ovf;

   int errs = 0, checks = 0;
   bit done = 1'b0;
   int m_en = 0, m_batch = 0, m_pend = 0, m_cnt = 0;
   int m_cmp [2] = '{0, 0};
   int m_buf [2] = '{0, 0};

   always #5 clk = ~clk;

   itmr_top #(.CNT_W(W)) u_itmr_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count(count), .irq_cmp0(irq_cmp0),
      .irq_cmp1(irq_cmp1), .irq_ovf(irq_ovf)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // Checks the current cycle against the model, then advances one clock.
   task automatic step(input string ctx);
      int e0, e1, eo, en_n, st, xf, nc;
      int nb [2];
      int np;
      e0 = (m_en != 0 && m_cnt == m_buf[0]) ? 1 : 0;
      e1 = (m_en != 0 && m_cnt == m_buf[1]) ? 1 : 0;
      eo = (m_en != 0 && m_cnt == MAXV) ? 1 : 0;
      chk(int'(count) == m_cnt, {ctx, " R2 count"}, int'(count), m_cnt);
      chk(int'(irq_cmp0) == e0, {ctx, " R4 irq_cmp0"}, int'(irq_cmp0), e0);
      chk(int'(irq_cmp1) == e1, {ctx, " R5 irq_cmp1"}, int'(irq_cmp1), e1);
      chk(int'(irq_ovf) == eo, {ctx, " R6 irq_ovf"}, int'(irq_ovf), eo);
      en_n = (wr_en && wr_addr == 2'd0) ? int'(wr_data[0]) : m_en;
      st = (en_n != 0 && m_en == 0) ? 1 : 0;
      xf = (e0 != 0 && m_pend != 0) ? 1 : 0;
      if (en_n == 0 || m_en == 0) nc = 0;
      else if (m_cnt == m_buf[0]) nc = 0;
      else nc = (m_cnt + 1) % (MAXV + 1);
      nb[0] = m_buf[0];
      nb[1] = m_buf[1];
      if (st != 0 || xf != 0) begin
         nb[0] = m_cmp[0];
         nb[1] = m_cmp[1];
      end else if (wr_en && m_batch == 0) begin
         if (wr_addr == 2'd1) nb[0] = int'(wr_data);
         if (wr_addr == 2'd2) nb[1] = int'(wr_data);
      end
      np = m_pend;
      if (wr_en && wr_addr == 2'd2 && m_batch != 0) np = 1;
      else if (xf != 0 || st != 0) np = 0;
      if (wr_en && wr_addr == 2'd1) m_cmp[0] = int'(wr_data);
      if (wr_en && wr_addr == 2'd2) m_cmp[1] = int'(wr_data);
      if (wr_en && wr_addr == 2'd0) m_batch = int'(wr_data[1]);
      m_en = en_n;
      m_cnt = nc;
      m_buf[0] = nb[0];
      m_buf[1] = nb[1];
      m_pend = np;
      @(negedge clk);
   endtask

   task automatic wr(input int addr, input int data, input string ctx);
      wr_en = 1'b1;
      wr_addr = 2'(addr);
      wr_data = W'(data);
      step(ctx);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n, input string ctx);
      for (int i = 0; i < n; i++) step(ctx);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired (all requirements)");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(count == '0, "R1 count", int'(count), 0);
      chk(irq_cmp0 == 1'b0 && irq_cmp1 == 1'b0 && irq_ovf == 1'b0,
          "R1 irqs", int'({irq_cmp0, irq_cmp1, irq_ovf}), 0);
      rst_n = 1'b1;
      run(4, "R1 idle");

      // Table walk in immediate mode
      for (int v = 0; v < NVEC; v++) begin
         wr(0, 0, "R10 stop");
         wr(1, VEC[v][0], "R7 setup");
         wr(2, VEC[v][1], "R7 setup");
         wr(0, 1, "R3 start");
         run(VEC[v][2], "table");
      end

      // R10: disable while running
      wr(0, 0, "R10");
      chk(count == '0, "R10 count after disable", int'(count), 0);
      chk({irq_cmp0, irq_cmp1, irq_ovf} == 3'b000, "R10 irqs off",
          int'({irq_cmp0, irq_cmp1, irq_ovf}), 0);
      run(12, "R10 idle");

      // R3: batch-mode writes while disabled are picked up at enable
      wr(0, 2, "R3 batch off");
      wr(1, 5, "R3");
      wr(2, 3, "R3");
      wr(0, 3, "R3 enable");
      chk(count == '0, "R3 count at start", int'(count), 0);
      run(5, "R3");
      chk(irq_cmp0 == 1'b1, "R3 irq_cmp0 at count 5", int'(irq_cmp0), 1);
      run(10, "R3");

      // R8: batch update commits at the next compare-0 match
      wr(1, 9, "R8");
      wr(2, 4, "R8");
      run(40, "R8");

      // R9: compare-0 write alone never commits in batch mode
      wr(1, 2, "R9");
      run(40, "R9");

      // R7: immediate updates while running
      wr(0, 1, "R7 mode");
      wr(1, 20, "R7");
      wr(2, 15, "R7");
      run(10, "R7");
      wr(1, 12, "R7");
      chk(irq_cmp0 == 1'b0, "R7 no early match", int'(irq_cmp0), 0);
      run(30, "R7");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule